// File: doc/BRIEF.md
# Interleaved Two-Phase PWM Generator

This block produces the four gate enables of a two-phase synchronous buck stage from a shared base oscillator tick. Each tick goes to one phase, and consecutive ticks alternate between the phases. Each phase therefore switches at half the tick rate, and the two phases run half a period apart. Phase A is the master channel. Phase B takes its own duty command, which a separate current-balance loop produces.

When a phase starts its period it samples its 10-bit duty word, clamps it to 95 percent and converts it into a high-side on-time in system clock cycles. For the rest of that period the phase requests the high side and then the low side. A per-phase break-before-make stage turns those requests into gate enables. It guarantees `DEAD_CYC` cycles with both enables low before either enable rises. A global enable stops both phases and forces every output low.

Top module: `ilv_pwm`

## Requirements
- R1: The first tick accepted while enabled starts phase A. Each later accepted tick starts the other phase from the one before, so A and B alternate.
- R2: At its start a phase latches on-time = floor(min(duty,972) * PER_CYC / 1024) cycles. The phase requests its high side while fewer than on-time cycles have elapsed since the start, and requests its low side for the rest of the period.
- R3: A duty word above 972 (95 percent of 1024) behaves exactly like 972.
- R4: A duty word of 0 keeps the high-side output low for the whole period, and the low side stays on.
- R5: A high-side output rises only after its own phase's two outputs have both been low for at least DEAD_CYC consecutive cycles.
- R6: A low-side output rises only after its own phase's two outputs have both been low for at least DEAD_CYC consecutive cycles.
- R7: The high-side and low-side outputs of the same phase are never high in the same cycle.
- R8: A phase samples its duty word only in the cycle of its own start tick. A change to the word during the period does not change that period's pulse.
- R9: One cycle after en_i is sampled low, all four outputs are low and stay low while en_i stays low. Ticks are ignored during that time. After en_i returns high, the next tick starts phase A.
- R10: Each phase uses only its own duty word, so the two phases can carry different pulse widths at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global enable; low forces all gates off |
| tick_i | input | 1 | Base oscillator tick, one cycle wide |
| duty_a_i | input | 10 | Duty word of phase A (master) |
| duty_b_i | input | 10 | Duty word of phase B (slave) |
| hs_a_o | output | 1 | High-side gate enable, phase A |
| ls_a_o | output | 1 | Low-side gate enable, phase A |
| hs_b_o | output | 1 | High-side gate enable, phase B |
| ls_b_o | output | 1 | Low-side gate enable, phase B |

## Verification
A tick sampled at an edge changes the request state at that edge, and the gate stage registers it one edge later. A phase that was idle therefore raises its first gate one cycle after its tick. A phase whose low side was on raises its high side DEAD_CYC+1 cycles after the tick, which makes a steady high pulse last on-time minus DEAD_CYC cycles. A disable shows up on the outputs one edge after en_i is sampled low. The bench drives inputs on falling edges. A behavioural model advances on the rising edge, and the outputs are compared with it on every falling edge. Pulse-width checks count high cycles over whole periods in steady state, so they do not depend on where the window is placed.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;
  localparam int unsigned NPH = 2;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_t;
endpackage

// File: rtl/ilv_phase_sched.sv
module ilv_phase_sched
  import ilv_pwm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           tick_i,
  output logic [NPH-1:0] start_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (!en_i)   sel_q <= 1'b0;
    else if (tick_i)  sel_q <= ~sel_q;
  end

  assign start_o[0] = en_i && tick_i && !sel_q;
  assign start_o[1] = en_i && tick_i &&  sel_q;
endmodule

// File: rtl/ilv_phase_timer.sv
module ilv_phase_timer #(
  parameter int unsigned DUTY_W  = 10,
  parameter int unsigned PER_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              want_hs_o,
  output logic              want_ls_o
);
  localparam int unsigned CNT_W = $clog2(PER_CYC) + 2;
  localparam int unsigned PW    = DUTY_W + CNT_W;
  localparam int unsigned DMAX  = (95 * (1 << DUTY_W)) / 100;
  localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(DMAX);
  localparam logic [CNT_W-1:0]  PER_L    = CNT_W'(PER_CYC);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q, on_q, on_nxt;
  logic [DUTY_W-1:0] dc;
  logic [PW-1:0]     prod;

  assign dc     = (duty_i > DUTY_MAX) ? DUTY_MAX : duty_i;
  assign prod   = {{CNT_W{1'b0}}, dc} * {{DUTY_W{1'b0}}, PER_L};
  assign on_nxt = prod[PW-1:DUTY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= CNT_MAX;
      on_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      on_q  <= on_nxt;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign want_hs_o = en_i && run_q && (cnt_q < on_q);
  assign want_ls_o = en_i && run_q && !(cnt_q < on_q);
endmodule

// File: rtl/ilv_deadband.sv
module ilv_deadband
  import ilv_pwm_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  want_hs_i,
  input  logic  want_ls_i,
  output gate_t gate_o
);
  localparam int unsigned GW = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [GW-1:0] DEAD_L = GW'(DEAD_CYC);

  logic          hs_q, ls_q;
  logic [GW-1:0] gap_q;  // completed both-low cycles, saturating

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= DEAD_L;
    end else if (!want_hs_i && !want_ls_i) begin
      if (hs_q || ls_q) begin
        hs_q  <= 1'b0;
        ls_q  <= 1'b0;
        gap_q <= GW'(1);
      end else if (gap_q < DEAD_L) begin
        gap_q <= gap_q + 1'b1;
      end
    end else if (want_hs_i) begin
      if (ls_q) begin
        ls_q  <= 1'b0;
        gap_q <= GW'(1);
      end else if (!hs_q) begin
        if (gap_q >= DEAD_L) hs_q  <= 1'b1;
        else                 gap_q <= gap_q + 1'b1;
      end
    end else begin
      if (hs_q) begin
        hs_q  <= 1'b0;
        gap_q <= GW'(1);
      end else if (!ls_q) begin
        if (gap_q >= DEAD_L) ls_q  <= 1'b1;
        else                 gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign gate_o.hs = hs_q;
  assign gate_o.ls = ls_q;
endmodule

// File: rtl/ilv_pwm.sv
module ilv_pwm
  import ilv_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W   = 10,
  parameter int unsigned PER_CYC  = 200,
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  output logic              hs_a_o,
  output logic              ls_a_o,
  output logic              hs_b_o,
  output logic              ls_b_o
);
  logic [NPH-1:0]    start;
  logic [DUTY_W-1:0] duty [NPH];
  gate_t             gate [NPH];

  assign duty[0] = duty_a_i;
  assign duty[1] = duty_b_i;

  ilv_phase_sched u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .start_o (start)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic want_hs, want_ls;

    ilv_phase_timer #(.DUTY_W(DUTY_W), .PER_CYC(PER_CYC)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .start_i   (start[p]),
      .duty_i    (duty[p]),
      .want_hs_o (want_hs),
      .want_ls_o (want_ls)
    );

    ilv_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .want_hs_i (want_hs),
      .want_ls_i (want_ls),
      .gate_o    (gate[p])
    );
  end

  assign hs_a_o = gate[0].hs;
  assign ls_a_o = gate[0].ls;
  assign hs_b_o = gate[1].hs;
  assign ls_b_o = gate[1].ls;
endmodule

// File: rtl/ilv_pwm_chk.sv
module ilv_pwm_chk #(
  parameter int unsigned DEAD_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic hs_a_o,
  input logic ls_a_o,
  input logic hs_b_o,
  input logic ls_b_o
);
  int unsigned low_a_q, low_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_a_q <= DEAD_CYC;
      low_b_q <= DEAD_CYC;
    end else begin
      low_a_q <= (hs_a_o || ls_a_o) ? 0 : ((low_a_q < DEAD_CYC) ? low_a_q + 1 : low_a_q);
      low_b_q <= (hs_b_o || ls_b_o) ? 0 : ((low_b_q < DEAD_CYC) ? low_b_q + 1 : low_b_q);
    end
  end

  AST_NO_OVERLAP_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_a_o && ls_a_o)); // R7
  AST_NO_OVERLAP_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_b_o && ls_b_o)); // R7
  AST_DEAD_HS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_a_o) |-> low_a_q >= DEAD_CYC); // R5
  AST_DEAD_HS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_b_o) |-> low_b_q >= DEAD_CYC); // R5
  AST_DEAD_LS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_a_o) |-> low_a_q >= DEAD_CYC); // R6
  AST_DEAD_LS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_b_o) |-> low_b_q >= DEAD_CYC); // R6
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o)); // R9
endmodule

bind ilv_pwm ilv_pwm_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .hs_a_o (hs_a_o),
  .ls_a_o (ls_a_o),
  .hs_b_o (hs_b_o),
  .ls_b_o (ls_b_o)
);

// File: tb/tb_ilv_pwm.sv
module tb_ilv_pwm;
  localparam int DEAD = 3;
  localparam int PER  = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic tick_i = 1'b0;
  logic [9:0] duty_a_i = '0;
  logic [9:0] duty_b_i = '0;
  logic hs_a_o, ls_a_o, hs_b_o, ls_b_o;

  int chk = 0;
  int err = 0;
  string cur_req = "R2";
  int acc_hs [2];
  int acc_ls [2];
  int acc_any;

  always #10 clk = ~clk;

  ilv_pwm dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_i),
    .duty_a_i(duty_a_i), .duty_b_i(duty_b_i),
    .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o)
  );

  // behavioural reference
  int m_sel;
  int m_run [2];
  int m_cnt [2];
  int m_on  [2];
  int m_hs  [2];
  int m_ls  [2];
  int m_gap [2];

  function automatic int on_of(int d);
    int c;
    c = (d > 972) ? 972 : d;
    return (c * PER) / 1024;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_sel = 0;
      for (int p = 0; p < 2; p++) begin
        m_run[p] = 0; m_cnt[p] = 1023; m_on[p] = 0;
        m_hs[p] = 0; m_ls[p] = 0; m_gap[p] = DEAD;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        bit wh, wl;
        wh = en_i && m_run[p] != 0 && m_cnt[p] < m_on[p];
        wl = en_i && m_run[p] != 0 && m_cnt[p] >= m_on[p];
        if (!wh && !wl) begin
          if (m_hs[p] != 0 || m_ls[p] != 0) begin m_hs[p] = 0; m_ls[p] = 0; m_gap[p] = 1; end
          else if (m_gap[p] < DEAD) m_gap[p]++;
        end else if (wh) begin
          if (m_ls[p] != 0) begin m_ls[p] = 0; m_gap[p] = 1; end
          else if (m_hs[p] == 0) begin
            if (m_gap[p] >= DEAD) m_hs[p] = 1; else m_gap[p]++;
          end
        end else begin
          if (m_hs[p] != 0) begin m_hs[p] = 0; m_gap[p] = 1; end
          else if (m_ls[p] == 0) begin
            if (m_gap[p] >= DEAD) m_ls[p] = 1; else m_gap[p]++;
          end
        end
      end
      if (!en_i) begin
        m_run[0] = 0; m_run[1] = 0; m_sel = 0;
      end else begin
        for (int p = 0; p < 2; p++) begin
          if (tick_i && m_sel == p) begin
            m_run[p] = 1; m_cnt[p] = 0;
            m_on[p] = on_of(p == 0 ? int'(duty_a_i) : int'(duty_b_i));
          end else if (m_cnt[p] < 1023) m_cnt[p]++;
        end
        if (tick_i) m_sel = 1 - m_sel;
      end
    end
  end

  // per-cycle comparison and gap tracking
  int low_run [2] = '{100, 100};
  logic prev_hs [2] = '{1'b0, 1'b0};
  logic prev_ls [2] = '{1'b0, 1'b0};

  always @(negedge clk) begin
    if (rst_ni) begin
      logic hs [2];
      logic ls [2];
      hs[0] = hs_a_o; ls[0] = ls_a_o; hs[1] = hs_b_o; ls[1] = ls_b_o;
      for (int p = 0; p < 2; p++) begin
        chk++;
        if (hs[p] !== m_hs[p][0] || ls[p] !== m_ls[p][0]) begin
          err++;
          $display("FAIL %s phase %0d hs/ls got %b%b exp %0d%0d at %0t",
                   cur_req, p, hs[p], ls[p], m_hs[p], m_ls[p], $time);
        end
        chk++;
        if (hs[p] && ls[p]) begin  // R7
          err++;
          $display("FAIL R7 phase %0d overlap got 11 exp not 11", p);
        end
        if (hs[p] && !prev_hs[p]) begin  // R5
          chk++;
          if (low_run[p] < DEAD) begin
            err++;
            $display("FAIL R5 phase %0d low gap got %0d exp >=%0d", p, low_run[p], DEAD);
          end
        end
        if (ls[p] && !prev_ls[p]) begin  // R6
          chk++;
          if (low_run[p] < DEAD) begin
            err++;
            $display("FAIL R6 phase %0d low gap got %0d exp >=%0d", p, low_run[p], DEAD);
          end
        end
        low_run[p] = (hs[p] || ls[p]) ? 0 : low_run[p] + 1;
        prev_hs[p] = hs[p];
        prev_ls[p] = ls[p];
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      tick_i = 1'b0;
      acc_hs[0] += int'(hs_a_o); acc_ls[0] += int'(ls_a_o);
      acc_hs[1] += int'(hs_b_o); acc_ls[1] += int'(ls_b_o);
      acc_any += int'(hs_a_o | ls_a_o | hs_b_o | ls_b_o);
    end
  endtask

  task automatic clr();
    acc_hs[0] = 0; acc_hs[1] = 0; acc_ls[0] = 0; acc_ls[1] = 0; acc_any = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick_i = 1'b1;
      step(100);
    end
  endtask

  task automatic expect_eq(string req, string what, int got, int exp);
    chk++;
    if (got != exp) begin
      err++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  initial begin
    clr();
    step(3);
    expect_eq("R9", "reset outputs", int'({hs_a_o, ls_a_o, hs_b_o, ls_b_o}), 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    duty_a_i = 10'd512;
    duty_b_i = 10'd256;
    step(2);

    cur_req = "R1";
    tick_i = 1'b1;
    step(5);
    expect_eq("R1", "first tick hs_a", int'(hs_a_o), 1);
    expect_eq("R1", "first tick phase B idle", int'(hs_b_o | ls_b_o), 0);
    step(95);
    tick_i = 1'b1;
    step(5);
    expect_eq("R1", "second tick hs_b", int'(hs_b_o), 1);
    step(95);

    cur_req = "R2";
    ticks(6);
    clr();
    ticks(4);
    expect_eq("R2", "hs_a width 512", acc_hs[0], 2 * (100 - DEAD));
    expect_eq("R10", "hs_b width 256", acc_hs[1], 2 * (50 - DEAD));

    cur_req = "R3";
    duty_a_i = 10'd1023;
    duty_b_i = 10'd973;
    ticks(6);
    clr();
    ticks(4);
    expect_eq("R3", "hs_a width 1023 clamped", acc_hs[0], 2 * (189 - DEAD));
    expect_eq("R3", "hs_b width 973 clamped", acc_hs[1], 2 * (189 - DEAD));

    cur_req = "R4";
    duty_a_i = 10'd0;
    duty_b_i = 10'd512;
    ticks(6);
    clr();
    ticks(4);
    expect_eq("R4", "hs_a width duty 0", acc_hs[0], 0);
    expect_eq("R4", "ls_a on whole window", acc_ls[0], 400);
    expect_eq("R10", "hs_b width 512", acc_hs[1], 2 * (100 - DEAD));

    cur_req = "R8";
    duty_a_i = 10'd512;
    ticks(6);
    clr();
    tick_i = 1'b1;
    step(30);
    duty_a_i = 10'd100;
    step(70);
    tick_i = 1'b1;
    step(50);
    duty_a_i = 10'd512;
    step(50);
    expect_eq("R8", "hs_a width with mid-period change", acc_hs[0], 100 - DEAD);

    cur_req = "R9";
    ticks(3);
    tick_i = 1'b1;
    step(20);
    en_i = 1'b0;
    step(1);
    expect_eq("R9", "outputs one cycle after disable", int'({hs_a_o, ls_a_o, hs_b_o, ls_b_o}), 0);
    clr();
    step(79);
    ticks(3);
    expect_eq("R9", "outputs during disable", acc_any, 0);
    en_i = 1'b1;
    step(10);
    tick_i = 1'b1;
    step(5);
    expect_eq("R9", "resume starts phase A", int'(hs_a_o), 1);
    expect_eq("R9", "resume phase B idle", int'(hs_b_o | ls_b_o), 0);
    step(95);
    tick_i = 1'b1;
    step(5);
    expect_eq("R1", "after resume next tick phase B", int'(hs_b_o), 1);
    step(95);
    ticks(4);

    $display("  CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  end

  initial begin
    #(200000 * 20);
    err++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  end
endmodule